// File: doc/BRIEF.md
# Oversampling Serial Word Receiver

This block turns an asynchronous serial line into parallel data words. It runs on a receive clock at sixteen times the bit rate. It watches the line for a falling edge and confirms a start bit at the middle of that bit. It then samples each data bit, an optional parity bit and the stop bit at the middle of their bit periods. The word is assembled least significant bit first and placed in an 8-bit holding register. The block then raises a ready flag for the host.

The word length, parity enable and parity sense come in as static configuration inputs. The configuration is captured when a start bit is confirmed, so a change during a frame affects only the next frame. The host acknowledges a word with an active-low pulse, which drops the ready flag. Errors for parity, framing and overrun are reported on three flags. Once one of these flags is set, it stays set until the master reset, and the acknowledge does not clear it. The master reset clears the flags without waiting for a clock edge and returns the receiver to idle. It leaves the last received word in the holding register.

Top module: `async_rx_core`

## Requirements
- R1: While `mrst` is high, `data_ready`, `err_parity`, `err_frame` and `err_overrun` are 0. They are cleared as soon as `mrst` rises, without waiting for a clock edge.
- R2: Asserting `mrst` does not change `rx_data`.
- R3: `mrst` returns the receiver to idle, discarding any frame in progress. A frame whose start bit begins right after `mrst` falls is received correctly.
- R4: A start bit is accepted only if the line is still low 8 receive clocks after the falling edge. A low pulse shorter than that produces no word.
- R5: `cfg_len` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first, and the unused upper bits of `rx_data` are 0.
- R6: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` = 0, the data bits plus the parity bit must hold an even number of ones. With `cfg_par_odd` = 1, they must hold an odd number. A mismatch sets `err_parity`.
- R7: A low sample at the middle of the stop bit sets `err_frame`.
- R8: If a word completes while `data_ready` is still 1 and no acknowledge is present, `err_overrun` is set. The new word replaces the old one in `rx_data`.
- R9: Driving `ack_n` low for one receive clock clears `data_ready`. It leaves `rx_data` unchanged.
- R10: The three error flags stay at 1 once set. Neither acknowledges nor later error-free frames clear them; only `mrst` does.
- R11: Only one stop bit is checked. A frame that follows the previous stop bit with no idle time is received correctly.
- R12: `data_ready` rises when a word completes, at the middle of its stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock, 16 times the bit rate |
| mrst | input | 1 | Master reset, active high, asynchronous assertion |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Word length select (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| ack_n | input | 1 | Active-low acknowledge that clears data_ready |
| rx_data | output | 8 | Last received word, upper unused bits zero |
| data_ready | output | 1 | A new word is waiting |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The bench builds the receiver with its default values: 16 clocks per bit and an 8-bit holding register. With these values all four length codes are reachable, and a 5-bit word can show that the three upper bits read zero. The 16-clock bit period is short enough that a rejected 4-clock glitch and back-to-back frames fit in a short run. A sticky flag can then be followed through acknowledges, clean frames and a reset that arrives between clock edges.

// File: rtl/async_rx_core.sv
module async_rx_core #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_rx,
  input  logic          mrst,
  input  logic          rx_in,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          ack_n,
  output logic [DW-1:0] rx_data,
  output logic          data_ready,
  output logic          err_parity,
  output logic          err_frame,
  output logic          err_overrun
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] shreg;
  logic          pbit;
  logic [1:0]    len_q;
  logic          pen_q, odd_q;

  wire           line     = sync_q[1];
  wire           tick     = (cnt == CW'(OVS - 1));
  wire           mid      = (cnt == CW'(HALF - 1));
  wire [BW-1:0]  last_idx = BW'(DW - 4) + BW'(len_q);
  wire           done     = (st == S_STOP) && tick;
  wire           par_bad  = pen_q && ((^shreg ^ pbit) != odd_q);

  always_ff @(posedge clk_rx or posedge mrst)
    if (mrst) sync_q <= 2'b11;
    else      sync_q <= {sync_q[0], rx_in};

  always_ff @(posedge clk_rx or posedge mrst) begin
    if (mrst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      len_q   <= 2'b11;
      pen_q   <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!line) st <= S_START;
        end
        S_START: begin
          cnt <= cnt + 1'b1;
          if (mid) begin
            cnt <= '0;
            if (!line) begin
              st      <= S_DATA;
              bit_idx <= '0;
              shreg   <= '0;
              len_q   <= cfg_len;
              pen_q   <= cfg_par_en;
              odd_q   <= cfg_par_odd;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_DATA: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) begin
            shreg[bit_idx] <= line;
            bit_idx        <= bit_idx + 1'b1;
            if (bit_idx == last_idx) st <= pen_q ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) begin
            pbit <= line;
            st   <= S_STOP;
          end
        end
        S_STOP: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_rx)
    if (done) rx_data <= shreg;

  always_ff @(posedge clk_rx or posedge mrst) begin
    if (mrst) begin
      data_ready  <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else if (done) begin
      data_ready  <= 1'b1;
      err_frame   <= err_frame | ~line;
      err_parity  <= err_parity | par_bad;
      err_overrun <= err_overrun | (data_ready & ack_n);
    end else if (!ack_n) begin
      data_ready  <= 1'b0;
    end
  end
endmodule

// File: rtl/async_rx_core_chk.sv
module async_rx_core_chk (
  input logic clk_rx,
  input logic mrst,
  input logic data_ready,
  input logic err_parity,
  input logic err_frame,
  input logic err_overrun
);
  always @(posedge clk_rx)
    if (mrst) AST_RST_CLEARS_FLAGS: assert (!data_ready && !err_parity && !err_frame && !err_overrun); // R1

  AST_PARITY_STICKY: assert property (@(posedge clk_rx) disable iff (mrst) err_parity |=> err_parity); // R10
  AST_FRAME_STICKY: assert property (@(posedge clk_rx) disable iff (mrst) err_frame |=> err_frame); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk_rx) disable iff (mrst) err_overrun |=> err_overrun); // R10
  AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk_rx) disable iff (mrst) $rose(err_overrun) |-> $past(data_ready)); // R8
endmodule

bind async_rx_core async_rx_core_chk u_chk (
  .clk_rx(clk_rx), .mrst(mrst), .data_ready(data_ready),
  .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/async_rx_core_bench.sv
`timescale 1ns/1ps
module async_rx_core_bench;
  logic       clk = 1'b0;
  logic       mrst = 1'b1;
  logic       rx = 1'b1;
  logic [1:0] len = 2'd3;
  logic       pen = 1'b0;
  logic       odd = 1'b0;
  logic       ack_n = 1'b1;
  logic [7:0] rx_data;
  logic       dr, pe, fe, oe;
  int         n_run = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  async_rx_core u_async_rx_core (
    .clk_rx(clk), .mrst(mrst), .rx_in(rx), .cfg_len(len), .cfg_par_en(pen),
    .cfg_par_odd(odd), .ack_n(ack_n), .rx_data(rx_data), .data_ready(dr),
    .err_parity(pe), .err_frame(fe), .err_overrun(oe)
  );

  // fields: len[23:22] pen[21] odd[20] flip[19] badstop[18] data[17:10] exp[9:2] pe[1] fe[0]
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h1F, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h03, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD5, 8'h55, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 8'h01, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h03, 8'h03, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h07, 8'h07, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h2A, 8'h2A, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0A, 8'h0A, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip, input logic badstop);
    int n;
    logic [7:0] m;
    n = 5 + int'(len);
    m = d & 8'((1 << n) - 1);
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (pen) send_bit(^m ^ odd ^ flip);
    send_bit(~badstop);
    rx = 1'b1;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    mrst = 1'b1;
    repeat (2) @(negedge clk);
    mrst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic acknowledge();
    @(negedge clk);
    ack_n = 1'b0;
    @(negedge clk);
    ack_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    mrst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset dr", int'(dr), 0);
    check("R1 reset pe", int'(pe), 0);
    check("R1 reset fe", int'(fe), 0);
    check("R1 reset oe", int'(oe), 0);

    for (int v = 0; v < NV; v++) begin
      pulse_reset();
      len = VEC[v][23:22];
      pen = VEC[v][21];
      odd = VEC[v][20];
      send_frame(VEC[v][17:10], VEC[v][19], VEC[v][18]);
      check("R5 data", int'(rx_data), int'(VEC[v][9:2]));
      check("R6 parity flag", int'(pe), int'(VEC[v][1]));
      check("R7 frame flag", int'(fe), int'(VEC[v][0]));
      check("R12 ready after word", int'(dr), 1);
    end

    // R1: clear between clock edges
    @(negedge clk);
    #1 mrst = 1'b1;
    #0.5;
    check("R1 async clear fe", int'(fe), 0);
    check("R1 async clear dr", int'(dr), 0);
    @(negedge clk);
    mrst = 1'b0;
    pen = 1'b0; odd = 1'b0; len = 2'd3;
    repeat (2) @(negedge clk);

    // R3 frame right after release, R12 ready low before it
    check("R12 ready low before word", int'(dr), 0);
    send_frame(8'h3C, 1'b0, 1'b0);
    check("R3 frame after release", int'(rx_data), 8'h3C);

    // R2 reset keeps buffer
    pulse_reset();
    check("R2 buffer kept", int'(rx_data), 8'h3C);

    // R3 reset mid-frame
    rx = 1'b0;
    repeat (40) @(negedge clk);
    mrst = 1'b1;
    rx = 1'b1;
    repeat (3) @(negedge clk);
    mrst = 1'b0;
    repeat (2) @(negedge clk);
    send_frame(8'hC3, 1'b0, 1'b0);
    check("R3 after aborted frame", int'(rx_data), 8'hC3);
    check("R3 no frame error", int'(fe), 0);

    // R9 acknowledge
    acknowledge();
    check("R9 ready cleared", int'(dr), 0);
    check("R9 data kept", int'(rx_data), 8'hC3);

    // R8 overrun
    send_frame(8'h11, 1'b0, 1'b0);
    send_frame(8'h22, 1'b0, 1'b0);
    check("R8 overrun set", int'(oe), 1);
    check("R8 new word kept", int'(rx_data), 8'h22);

    // R10 sticky through ack and clean frame
    acknowledge();
    check("R10 overrun after ack", int'(oe), 1);
    send_frame(8'h33, 1'b0, 1'b0);
    check("R10 overrun after clean frame", int'(oe), 1);
    pulse_reset();
    pen = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b0);
    acknowledge();
    send_frame(8'h5B, 1'b0, 1'b0);
    check("R10 parity sticky", int'(pe), 1);
    check("R10 overrun clean", int'(oe), 0);
    pen = 1'b0;

    // R4 short glitch rejected
    pulse_reset();
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (60) @(negedge clk);
    check("R4 glitch no word", int'(dr), 0);
    check("R4 glitch no frame error", int'(fe), 0);

    // R11 back-to-back frames with one stop bit
    send_frame(8'h0F, 1'b0, 1'b0);
    check("R11 first word", int'(rx_data), 8'h0F);
    send_frame(8'hF0, 1'b0, 1'b0);
    check("R11 second word", int'(rx_data), 8'hF0);
    check("R11 no frame error", int'(fe), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule